// File: doc/BRIEF.md
# Interrupt Controller Register File

This block is the memory-mapped register bank of a per-core interrupt controller. Software reaches it through one 32-bit read/write request port. Each request carries a byte offset inside a 4 KB page and a length. The block takes at most one request per cycle and answers every request exactly one cycle later. Each answer carries a response-valid strobe, an error flag and, for reads, the register contents.

Offsets are decoded on bits 11:3, so each register fills one 8-byte slot. Any slot outside the map gives an error response. The interrupt request, in-service and trigger arrays, the arbitration and processor priority registers and the command register are not held here, so their slots also answer with an error. An access whose bytes run past the end of their 8-byte slot is refused as well. Each register applies its own write rule:
- some fields are masked;
- the destination format register has forced ones;
- two bits of every vector-table entry are read-only;
- the version and current-count registers ignore writes.

The error-status register captures error events from the `err_log` input. It is cleared by a two-step handshake run by a small state machine with two states:
- `ES_DISARMED`: a write moves it to `ES_ARMED` (transition *arm*) and leaves the register unchanged.
- `ES_ARMED`: a write returns it to `ES_DISARMED` and zeroes the register (transition *clear*). A read also returns it to `ES_DISARMED` (transition *read-disarm*) and leaves the value unchanged.

A write to the end-of-interrupt slot is not stored. It is forwarded as a one-cycle `eoi_pulse` to the in-service logic. Bit 8 of the spurious-vector register drives `sw_enable`.

Top module: `lic_regfile`

## Requirements
- R1: After reset, reads return the following values:

  | Register | Reset value |
  |---|---|
  | ID | `CORE_ID` in bits 31:24 |
  | version | `VERSION_VAL` (default 0x00050014) |
  | destination format | 0xFFFFFFFF |
  | each of the six vector-table entries | 0x00010000 |
  | spurious vector | 0x000000FF |
  | all other mapped registers | 0 |

  `sw_enable` is 0 after reset.
- R2: Every request cycle with `req_valid` high is answered by `rsp_valid` high in the following cycle. A read returns the register value as it stood before the request's clock edge. A write answers with `rsp_rdata` = 0.
- R3: The mapped slot offsets are:

  | Register | Offset |
  |---|---|
  | ID | 0x20 |
  | version | 0x30 |
  | task priority | 0x80 |
  | EOI | 0xB0 |
  | logical destination | 0xD0 |
  | destination format | 0xE0 |
  | spurious vector | 0xF0 |
  | error status | 0x280 |
  | vector-table entries 0..5 | 0x320, 0x330, 0x340, 0x350, 0x360, 0x370 |
  | initial count | 0x380 |
  | current count | 0x390 |
  | divide configuration | 0x3E0 |

  Any other slot gives `rsp_err` = 1 and `rsp_rdata` = 0, and changes no register.
- R4: A request whose `req_offset[2:0]` + `req_len_m1` exceeds 7 gives `rsp_err` = 1 and writes nothing.
- R5: Writes keep only some bits:
  - ID keeps bits 31:24.
  - Task priority keeps bits 7:0.
  - Logical destination keeps bits 31:24.
  - Divide configuration keeps bits 3, 1 and 0.

  All other bits read 0.
- R6: A write to destination format stores the data ORed with 0x0FFFFFFF.
- R7: Writes to version and to current count are dropped. Current count reads 0.
- R8: A write to a vector-table entry stores every bit except 12 and 14, which keep their old value.
- R9: Error status follows the arm FSM:
  - a write while disarmed arms it and leaves the value unchanged;
  - a write while armed disarms it and zeroes the value;
  - a read disarms it.
- R10: In every cycle, the bits of `err_log` are ORed into error-status bits 7:0, including the cycle of a clearing write.
- R11: A write to the spurious-vector register stores all 32 bits. `sw_enable` equals bit 8 of the stored value from the cycle after the write.
- R12: A write to the EOI slot raises `eoi_pulse` for exactly the response cycle and stores nothing: EOI reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset inside the page |
| req_len_m1 | input | 3 | Access length in bytes minus one |
| req_wdata | input | 32 | Write data (whole register) |
| err_log | input | 8 | Error events ORed into error status |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Reserved slot or slot-spanning access |
| rsp_rdata | output | 32 | Read data |
| eoi_pulse | output | 1 | End-of-interrupt write seen |
| sw_enable | output | 1 | Software enable from spurious-vector bit 8 |

## Verification
Every result of a request is due exactly one clock edge after the edge that took the request: the response fields, `eoi_pulse`, a changed `sw_enable`, and register contents seen by a read in the next request. The bench drives each request on a falling edge and samples the answer on the following falling edge, with no gap between requests. A read that follows a write therefore sees the written value. Error events on `err_log` are held for one edge and are visible to a read issued right after.

// File: rtl/lic_pkg.sv
package lic_pkg;

    // Register selector produced by the slot decoder
    typedef enum logic [4:0] {
        SEL_ID       = 5'd0,
        SEL_VERSION  = 5'd1,
        SEL_TASKPRI  = 5'd2,
        SEL_EOI      = 5'd3,
        SEL_LOGDEST  = 5'd4,
        SEL_DESTFMT  = 5'd5,
        SEL_SPUR     = 5'd6,
        SEL_ERRSTAT  = 5'd7,
        SEL_VEC0     = 5'd8,
        SEL_VEC1     = 5'd9,
        SEL_VEC2     = 5'd10,
        SEL_VEC3     = 5'd11,
        SEL_VEC4     = 5'd12,
        SEL_VEC5     = 5'd13,
        SEL_TMR_INIT = 5'd14,
        SEL_TMR_CUR  = 5'd15,
        SEL_TMR_DIV  = 5'd16,
        SEL_NONE     = 5'd31
    } sel_e;

    // 8-byte slot numbers (offset >> 3)
    localparam int SLOT_ID        = 'h20  >> 3;
    localparam int SLOT_VERSION   = 'h30  >> 3;
    localparam int SLOT_TASKPRI   = 'h80  >> 3;
    localparam int SLOT_EOI       = 'hB0  >> 3;
    localparam int SLOT_LOGDEST   = 'hD0  >> 3;
    localparam int SLOT_DESTFMT   = 'hE0  >> 3;
    localparam int SLOT_SPUR      = 'hF0  >> 3;
    localparam int SLOT_ERRSTAT   = 'h280 >> 3;
    localparam int SLOT_VEC_FIRST = 'h320 >> 3;
    localparam int NUM_VEC        = 6;
    localparam int VEC_STRIDE     = 2;
    localparam int SLOT_VEC_LAST  = SLOT_VEC_FIRST + VEC_STRIDE * (NUM_VEC - 1);
    localparam int SLOT_TMR_INIT  = 'h380 >> 3;
    localparam int SLOT_TMR_CUR   = 'h390 >> 3;
    localparam int SLOT_TMR_DIV   = 'h3E0 >> 3;

    // Write rules
    localparam logic [31:0] DESTFMT_FORCE = 32'h0FFF_FFFF;
    localparam logic [31:0] VEC_RO_MASK   = 32'h0000_5000;
    localparam logic [31:0] VEC_RESET     = 32'h0001_0000;
    localparam logic [31:0] SPUR_RESET    = 32'h0000_00FF;
    localparam logic [3:0]  DIV_MASK      = 4'hB;
    localparam int          SPUR_EN_BIT   = 8;

endpackage

// File: rtl/lic_decode.sv
module lic_decode
    import lic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [2:0]        len_m1,
    output sel_e              sel,
    output logic              bad
);
    localparam int SLOT_W = ADDR_W - 3;

    logic [SLOT_W-1:0] slot;
    logic [3:0]        last_byte;
    int                slot_i;

    assign slot      = offset[ADDR_W-1:3];
    assign slot_i    = int'(slot);
    assign last_byte = {1'b0, offset[2:0]} + {1'b0, len_m1};

    always_comb begin
        sel = SEL_NONE;
        if (slot_i >= SLOT_VEC_FIRST && slot_i <= SLOT_VEC_LAST &&
            ((slot_i - SLOT_VEC_FIRST) % VEC_STRIDE) == 0) begin
            sel = sel_e'(5'(int'(SEL_VEC0) + (slot_i - SLOT_VEC_FIRST) / VEC_STRIDE));
        end else begin
            case (slot_i)
                SLOT_ID:       sel = SEL_ID;
                SLOT_VERSION:  sel = SEL_VERSION;
                SLOT_TASKPRI:  sel = SEL_TASKPRI;
                SLOT_EOI:      sel = SEL_EOI;
                SLOT_LOGDEST:  sel = SEL_LOGDEST;
                SLOT_DESTFMT:  sel = SEL_DESTFMT;
                SLOT_SPUR:     sel = SEL_SPUR;
                SLOT_ERRSTAT:  sel = SEL_ERRSTAT;
                SLOT_TMR_INIT: sel = SEL_TMR_INIT;
                SLOT_TMR_CUR:  sel = SEL_TMR_CUR;
                SLOT_TMR_DIV:  sel = SEL_TMR_DIV;
                default:       sel = SEL_NONE;
            endcase
        end
    end

    assign bad = (sel == SEL_NONE) || (last_byte > 4'd7);

endmodule

// File: rtl/lic_errstat.sv
module lic_errstat #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic [ERR_W-1:0] err_log,
    output logic [ERR_W-1:0] value
);
    typedef enum logic [0:0] {
        ES_DISARMED = 1'b0,
        ES_ARMED    = 1'b1
    } es_state_e;

    es_state_e        state_q, state_d;
    logic             clear_now;
    logic [ERR_W-1:0] value_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ES_DISARMED;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        clear_now = 1'b0;
        unique case (state_q)
            ES_DISARMED: begin
                if (wr_hit) state_d = ES_ARMED;            // arm
            end
            ES_ARMED: begin
                if (wr_hit) begin
                    state_d   = ES_DISARMED;               // clear
                    clear_now = 1'b1;
                end else if (rd_hit) begin
                    state_d   = ES_DISARMED;               // read-disarm
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= (clear_now ? '0 : value_q) | err_log;
    end

    assign value = value_q;

    AST_ARM_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ES_DISARMED && wr_hit) |=> (value_q == ($past(value_q) | $past(err_log)))); // R9
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ES_ARMED && wr_hit) |=> (value_q == $past(err_log))); // R9
    AST_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (state_q == ES_DISARMED)); // R9
    AST_LOG_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((value_q & $past(err_log)) == $past(err_log))); // R10

endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
    import lic_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          ERR_W       = 8,
    parameter logic [7:0]  CORE_ID     = 8'd3,
    parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [2:0]        req_len_m1,
    input  logic [31:0]       req_wdata,
    input  logic [ERR_W-1:0]  err_log,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              eoi_pulse,
    output logic              sw_enable
);
    localparam int VIDX_W = $clog2(NUM_VEC);

    sel_e        sel;
    logic        bad;
    logic        acc_ok, wr, rd;
    logic [31:0] rd_val;
    logic [VIDX_W-1:0] vidx;

    logic [7:0]  id_q, taskpri_q, logdest_q;
    logic [3:0]  destfmt_q;
    logic [31:0] spur_q, tmr_init_q;
    logic [3:0]  tmr_div_q;
    logic [31:0] vec_q [NUM_VEC];
    logic [ERR_W-1:0] es_val;

    logic        rsp_valid_q, rsp_err_q, eoi_q;
    logic [31:0] rsp_rdata_q;

    lic_decode #(.ADDR_W(ADDR_W)) u_decode (
        .offset (req_offset),
        .len_m1 (req_len_m1),
        .sel    (sel),
        .bad    (bad)
    );

    assign acc_ok = req_valid && !bad;
    assign wr     = acc_ok && req_write;
    assign rd     = acc_ok && !req_write;

    lic_errstat #(.ERR_W(ERR_W)) u_errstat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr && sel == SEL_ERRSTAT),
        .rd_hit  (rd && sel == SEL_ERRSTAT),
        .err_log (err_log),
        .value   (es_val)
    );

    // Plain and masked registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q       <= CORE_ID;
            taskpri_q  <= '0;
            logdest_q  <= '0;
            destfmt_q  <= '1;
            spur_q     <= SPUR_RESET;
            tmr_init_q <= '0;
            tmr_div_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_ID:       id_q       <= req_wdata[31:24];
                SEL_TASKPRI:  taskpri_q  <= req_wdata[7:0];
                SEL_LOGDEST:  logdest_q  <= req_wdata[31:24];
                SEL_DESTFMT:  destfmt_q  <= req_wdata[31:28];
                SEL_SPUR:     spur_q     <= req_wdata;
                SEL_TMR_INIT: tmr_init_q <= req_wdata;
                SEL_TMR_DIV:  tmr_div_q  <= req_wdata[3:0] & DIV_MASK;
                default: ;
            endcase
        end
    end

    // Vector-table entries with read-only bits
    for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
        localparam sel_e MY_SEL = sel_e'(5'(int'(SEL_VEC0) + gi));
        logic hit;
        assign hit = wr && (sel == MY_SEL);

        always_ff @(posedge clk) begin
            if (!rst_n)   vec_q[gi] <= VEC_RESET;
            else if (hit) vec_q[gi] <= (req_wdata & ~VEC_RO_MASK) | (vec_q[gi] & VEC_RO_MASK);
        end

        AST_VEC_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> ((vec_q[gi] & VEC_RO_MASK) == ($past(vec_q[gi]) & VEC_RO_MASK))); // R8
    end

    assign vidx = VIDX_W'(int'(sel) - int'(SEL_VEC0));

    // Read mux
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_ID:       rd_val = {id_q, 24'h0};
            SEL_VERSION:  rd_val = VERSION_VAL;
            SEL_TASKPRI:  rd_val = {24'h0, taskpri_q};
            SEL_LOGDEST:  rd_val = {logdest_q, 24'h0};
            SEL_DESTFMT:  rd_val = {destfmt_q, 28'h0} | DESTFMT_FORCE;
            SEL_SPUR:     rd_val = spur_q;
            SEL_ERRSTAT:  rd_val = {{(32-ERR_W){1'b0}}, es_val};
            SEL_VEC0, SEL_VEC1, SEL_VEC2,
            SEL_VEC3, SEL_VEC4, SEL_VEC5:
                          rd_val = vec_q[vidx];
            SEL_TMR_INIT: rd_val = tmr_init_q;
            SEL_TMR_DIV:  rd_val = {28'h0, tmr_div_q};
            default:      rd_val = '0;
        endcase
    end

    // Response stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
            eoi_q       <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && bad;
            rsp_rdata_q <= rd ? rd_val : '0;
            eoi_q       <= wr && (sel == SEL_EOI);
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;
    assign eoi_pulse = eoi_q;
    assign sw_enable = spur_q[SPUR_EN_BIT];

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0)); // R3
    AST_SPAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (({1'b0, req_offset[2:0]} + {1'b0, req_len_m1}) > 4'd7)) |=> rsp_err); // R4
    AST_DESTFMT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_DESTFMT) |=> (rsp_rdata[27:0] == 28'hFFF_FFFF)); // R6
    AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_VERSION) |=> (rsp_rdata == VERSION_VAL)); // R7
    AST_EOI_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> (rsp_valid && !rsp_err)); // R12
    AST_SWEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_SPUR) |=> (sw_enable == $past(req_wdata[SPUR_EN_BIT]))); // R11

endmodule

// File: tb/tb_lic_regfile.sv
`timescale 1ns/1ps
module tb_lic_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_offset = '0;
    logic [2:0]  req_len_m1 = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  err_log = '0;
    logic        rsp_valid, rsp_err, eoi_pulse, sw_enable;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] model [512];
    logic        got_valid, got_err, got_eoi;
    logic [31:0] got_data;

    always #10 clk = ~clk;

    lic_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_len_m1(req_len_m1), .req_wdata(req_wdata),
        .err_log(err_log), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .eoi_pulse(eoi_pulse), .sw_enable(sw_enable)
    );

    function automatic bit is_mapped(int s);
        if (s >= 100 && s <= 110 && (s % 2) == 0) return 1;
        return (s == 4 || s == 6 || s == 16 || s == 22 || s == 26 || s == 28 ||
                s == 30 || s == 80 || s == 112 || s == 114 || s == 124);
    endfunction

    function automatic bit is_vec(int s);
        return (s >= 100 && s <= 110 && (s % 2) == 0);
    endfunction

    function automatic logic [31:0] reset_val(int s);
        if (is_vec(s)) return 32'h0001_0000;
        case (s)
            4:  return 32'h0300_0000;
            6:  return 32'h0005_0014;
            28: return 32'hFFFF_FFFF;
            30: return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] after_write(int s, logic [31:0] old, logic [31:0] d);
        if (is_vec(s)) return (d & ~32'h5000) | (old & 32'h5000);
        case (s)
            4:   return d & 32'hFF00_0000;
            16:  return d & 32'h0000_00FF;
            26:  return d & 32'hFF00_0000;
            28:  return d | 32'h0FFF_FFFF;
            30:  return d;
            112: return d;
            124: return d & 32'h0000_000B;
            default: return old;   // version, EOI, current count
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic access(bit w, logic [11:0] off, logic [2:0] len, logic [31:0] d);
        req_valid  = 1'b1;
        req_write  = w;
        req_offset = off;
        req_len_m1 = len;
        req_wdata  = d;
        @(negedge clk);
        got_valid = rsp_valid;
        got_err   = rsp_err;
        got_data  = rsp_rdata;
        got_eoi   = eoi_pulse;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic pulse_err(logic [7:0] v);
        err_log = v;
        @(negedge clk);
        err_log = '0;
    endtask

    initial begin
        for (int s = 0; s < 512; s++) model[s] = reset_val(s);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 sw_enable reset", {31'h0, sw_enable}, 32'h0);
        check("R2 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);

        // Full read sweep of the page in reset state
        for (int s = 0; s < 512; s++) begin
            access(0, 12'(s * 8), 3'd3, 32'h0);
            check("R2 rsp_valid", {31'h0, got_valid}, 32'h1);
            check("R3 err flag", {31'h0, got_err}, {31'h0, !is_mapped(s)});
            check("R1 reset read", got_data, is_mapped(s) ? reset_val(s) : 32'h0);
        end

        // Write/readback sweep with several patterns
        for (int p = 0; p < 3; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_0000 : 32'hA5A5_5A5A;
            for (int s = 0; s < 512; s++) begin
                if (is_mapped(s) && s != 80) begin
                    access(1, 12'(s * 8), 3'd3, pat);
                    check("R2 write rsp_err", {31'h0, got_err}, 32'h0);
                    check("R2 write rdata zero", got_data, 32'h0);
                    check("R12 eoi pulse", {31'h0, got_eoi}, {31'h0, s == 22});
                    if (s == 30) check("R11 sw_enable", {31'h0, sw_enable}, {31'h0, pat[8]});
                    model[s] = after_write(s, model[s], pat);
                    access(0, 12'(s * 8), 3'd3, 32'h0);
                    check(s == 28 ? "R6 destfmt" : is_vec(s) ? "R8 vector ro bits" :
                          (s == 6 || s == 114) ? "R7 read-only" : s == 22 ? "R12 eoi not stored" :
                          s == 30 ? "R11 spur store" : "R5 masked write", got_data, model[s]);
                    check("R12 no eoi on read", {31'h0, got_eoi}, 32'h0);
                end
            end
        end

        // Writes to reserved slots must not disturb any register
        for (int s = 0; s < 512; s++) begin
            if (!is_mapped(s)) begin
                access(1, 12'(s * 8), 3'd3, 32'hFFFF_FFFF);
                check("R3 reserved write err", {31'h0, got_err}, 32'h1);
            end
        end
        for (int s = 0; s < 512; s++) begin
            if (is_mapped(s) && s != 80) begin
                access(0, 12'(s * 8), 3'd3, 32'h0);
                check("R3 no state change", got_data, model[s]);
            end
        end

        // Span sweep on the ID slot
        for (int o = 0; o < 8; o++) begin
            for (int l = 0; l < 8; l++) begin
                access(0, 12'(32 + o), 3'(l), 32'h0);
                check("R4 span err", {31'h0, got_err}, {31'h0, (o + l) > 7});
                check("R4 span data", got_data, ((o + l) > 7) ? 32'h0 : model[4]);
            end
        end
        access(1, 12'h086, 3'd3, 32'h0000_0077);
        check("R4 spanning write err", {31'h0, got_err}, 32'h1);
        access(0, 12'h080, 3'd3, 32'h0);
        check("R4 spanning write dropped", got_data, model[16]);

        // Error-status handshake
        pulse_err(8'h05);
        access(0, 12'h280, 3'd3, 32'h0);
        check("R10 capture", got_data, 32'h05);
        access(1, 12'h280, 3'd3, 32'h0);       // arm
        access(1, 12'h280, 3'd3, 32'h0);       // clear
        access(0, 12'h280, 3'd3, 32'h0);
        check("R9 armed write clears", got_data, 32'h0);
        pulse_err(8'h0A);
        access(1, 12'h280, 3'd3, 32'h0);       // arm
        access(0, 12'h280, 3'd3, 32'h0);       // read disarms
        check("R9 arming write keeps value", got_data, 32'h0A);
        access(1, 12'h280, 3'd3, 32'h0);       // arm again
        access(0, 12'h280, 3'd3, 32'h0);
        check("R9 read disarmed", got_data, 32'h0A);
        access(1, 12'h280, 3'd3, 32'h0);       // arm
        err_log = 8'h30;
        access(1, 12'h280, 3'd3, 32'h0);       // clear with concurrent event
        err_log = 8'h00;
        access(0, 12'h280, 3'd3, 32'h0);
        check("R10 event during clear", got_data, 32'h30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule